// File: doc/BRIEF.md
# Operating-System Tick Timer with Packed Reload Control

This block is a register-mapped timer peripheral for an operating-system tick. Behind a simple single-cycle bus slave port it holds two counters. The first is a free-running timestamp counter that software reads as a clock source. The second is a down-counting event timer that raises an interrupt each time it expires. The down-counter runs either periodically, reloading itself after each expiry, or once, stopping after the first expiry.

The event timer has no separate control register. The two lowest bits of its reload word act as the control bits: bit 0 enables the timer and bit 1 selects one-shot operation. The count loaded from that word always treats those two bits as zero, so every reload count is a multiple of four. A status word collects sticky pending flags that software clears by writing one to them. The timer's pending flag drives the interrupt output as a level.

Bus reads are combinational. Bus writes take effect at the clock edge on which the port is selected with the write strobe high.

Top module: `os_tick_timer`

## Requirements
- R1: While reset is asserted, every mapped register reads zero and `tick_irq` is low.
- R2: The timestamp (offset 0x00) increases by one on every clock edge. A write loads the written word, so writing 0 restarts it from zero.
- R3: When the timestamp steps from all ones to zero, status bit 2 (the timestamp pending flag) is set.
- R4: The reload/control word (offset 0x08) reads back exactly as written. Bit 0 is enable and bit 1 is one-shot. A write with bit 0 set loads the count (offset 0x04) on that edge with the written word's bits 1:0 forced to zero.
- R5: While enabled and non-zero, the count drops by one on each clock edge.
- R6: In periodic mode (bit 1 clear), an edge that finds the count at zero sets status bit 0 and reloads the masked reload value. With a masked reload value V, the period is V+1 cycles.
- R7: In one-shot mode (bit 1 set), an edge that finds the count at zero sets status bit 0, clears bit 0 of the reload/control word, and leaves the count at zero.
- R8: Status (offset 0x20) bit 0 is the timer pending flag and bit 2 is the timestamp pending flag. Bits 1, 3, 4 and all others read zero. Writing 1 to a flag clears it and writing 0 leaves it unchanged. If a new expiry falls on the same edge as the clear, the flag stays set.
- R9: `tick_irq` is high exactly while status bit 0 is set.
- R10: Reads of any offset other than 0x00, 0x04, 0x08 and 0x20 return zero. Writes to the count (0x04) or to unmapped offsets change nothing.
- R11: Writing 0 to the reload/control word disables the timer. The count then holds its value and no new expiry occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Slave selected for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the same cycle |
| tick_irq | output | 1 | Level interrupt from the timer pending flag |

## Verification
The properties assume that the bus issues at most one access per cycle and that its select, strobe, address and data are stable across each clock edge. The bench drives every access on the falling edge and releases it one nanosecond after the rising edge to stay within this assumption. The properties also assume that the only writes reaching the timestamp and reload words are intentional. The bench therefore sweeps reload values in multiples of four, in both modes, under bus traffic that it fully controls. It never issues a write that overlaps a count it is still observing.

// File: rtl/ostmr_pkg.sv
package ostmr_pkg;
   // byte offsets inside the peripheral window
   localparam int OFF_STAMP  = 'h00;
   localparam int OFF_COUNT  = 'h04;
   localparam int OFF_RELOAD = 'h08;
   localparam int OFF_STATUS = 'h20;
   // control bits packed into the reload word
   localparam int CTRL_BITS  = 2;
   localparam int BIT_EN     = 0;
   localparam int BIT_ONCE   = 1;
   // status bit positions
   localparam int ST_TIMER   = 0;
   localparam int ST_STAMP   = 2;
   // pending flag slots
   localparam int PF_TIMER   = 0;
   localparam int PF_STAMP   = 1;
   localparam int PF_COUNT   = 2;

   typedef enum logic [2:0] {
      SEL_NONE, SEL_STAMP, SEL_COUNT, SEL_RELOAD, SEL_STATUS
   } reg_sel_e;
endpackage

// File: rtl/ostmr_stamp.sv
module ostmr_stamp #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] value,
   output logic         wrap
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   generate
      if (W < 2) begin : g_bad_w
         $error("ostmr_stamp: W must be at least 2");
      end
   endgenerate

   assign wrap = (value == TOP) && !load;

   always_ff @(posedge clk) begin
      if (!rst_n)
         value <= '0;
      else if (load)
         value <= load_val;
      else
         value <= value + 1'b1;
   end
endmodule

// File: rtl/ostmr_countdown.sv
module ostmr_countdown
   import ostmr_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ctl_wr,
   input  logic [W-1:0] ctl_wdata,
   output logic [W-1:0] ctl_q,
   output logic [W-1:0] count_q,
   output logic         expire
);
   localparam int HI = W - 1;

   generate
      if (W <= CTRL_BITS + 1) begin : g_bad_w
         $error("ostmr_countdown: W too small for packed control bits");
      end
   endgenerate

   logic [W-1:0] reload_val;
   logic [W-1:0] wr_masked;
   logic         running;
   logic         once;

   assign reload_val = {ctl_q[HI:CTRL_BITS], {CTRL_BITS{1'b0}}};
   assign wr_masked  = {ctl_wdata[HI:CTRL_BITS], {CTRL_BITS{1'b0}}};
   assign running    = ctl_q[BIT_EN];
   assign once       = ctl_q[BIT_ONCE];
   assign expire     = running && (count_q == '0) && !ctl_wr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q   <= '0;
         count_q <= '0;
      end else if (ctl_wr) begin
         ctl_q <= ctl_wdata;
         if (ctl_wdata[BIT_EN])
            count_q <= wr_masked;
      end else if (expire) begin
         if (once)
            ctl_q[BIT_EN] <= 1'b0;
         else
            count_q <= reload_val;
      end else if (running) begin
         count_q <= count_q - 1'b1;
      end
   end
endmodule

// File: rtl/ostmr_flags.sv
module ostmr_flags #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_in,
   input  logic [N-1:0] clr_in,
   output logic [N-1:0] pend
);
   generate
      if (N < 1) begin : g_bad_n
         $error("ostmr_flags: N must be positive");
      end
      for (genvar i = 0; i < N; i++) begin : g_flag
         always_ff @(posedge clk) begin
            if (!rst_n)
               pend[i] <= 1'b0;
            else if (set_in[i])
               pend[i] <= 1'b1;
            else if (clr_in[i])
               pend[i] <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/os_tick_timer.sv
module os_tick_timer
   import ostmr_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              tick_irq
);
   localparam int MIN_ADDR_W = $clog2(OFF_STATUS + 1);

   generate
      if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
         $error("os_tick_timer: ADDR_W cannot reach the status offset");
      end
      if (DATA_W <= ST_STAMP) begin : g_bad_data
         $error("os_tick_timer: DATA_W too narrow for status bits");
      end
   endgenerate

   reg_sel_e          sel_reg;
   logic              wr_stamp, wr_reload, wr_status;
   logic [DATA_W-1:0] stamp_q, count_q, ctl_q, status_w;
   logic              stamp_wrap, t1_expire;
   logic [PF_COUNT-1:0] pend_q, pend_set, pend_clr;

   always_comb begin
      if (bus_addr == ADDR_W'(OFF_STAMP))       sel_reg = SEL_STAMP;
      else if (bus_addr == ADDR_W'(OFF_COUNT))  sel_reg = SEL_COUNT;
      else if (bus_addr == ADDR_W'(OFF_RELOAD)) sel_reg = SEL_RELOAD;
      else if (bus_addr == ADDR_W'(OFF_STATUS)) sel_reg = SEL_STATUS;
      else                                      sel_reg = SEL_NONE;
   end

   assign wr_stamp  = bus_sel && bus_wr && (sel_reg == SEL_STAMP);
   assign wr_reload = bus_sel && bus_wr && (sel_reg == SEL_RELOAD);
   assign wr_status = bus_sel && bus_wr && (sel_reg == SEL_STATUS);

   ostmr_stamp #(.W(DATA_W)) u_stamp (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_stamp),
      .load_val (bus_wdata),
      .value    (stamp_q),
      .wrap     (stamp_wrap)
   );

   ostmr_countdown #(.W(DATA_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_wr    (wr_reload),
      .ctl_wdata (bus_wdata),
      .ctl_q     (ctl_q),
      .count_q   (count_q),
      .expire    (t1_expire)
   );

   always_comb begin
      pend_set           = '0;
      pend_set[PF_TIMER] = t1_expire;
      pend_set[PF_STAMP] = stamp_wrap;
      pend_clr           = '0;
      pend_clr[PF_TIMER] = wr_status && bus_wdata[ST_TIMER];
      pend_clr[PF_STAMP] = wr_status && bus_wdata[ST_STAMP];
   end

   ostmr_flags #(.N(PF_COUNT)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_in (pend_set),
      .clr_in (pend_clr),
      .pend   (pend_q)
   );

   generate
      for (genvar b = 0; b < DATA_W; b++) begin : g_status
         if (b == ST_TIMER) begin : g_t
            assign status_w[b] = pend_q[PF_TIMER];
         end else if (b == ST_STAMP) begin : g_s
            assign status_w[b] = pend_q[PF_STAMP];
         end else begin : g_z
            assign status_w[b] = 1'b0;
         end
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr) begin
         case (sel_reg)
            SEL_STAMP:  bus_rdata = stamp_q;
            SEL_COUNT:  bus_rdata = count_q;
            SEL_RELOAD: bus_rdata = ctl_q;
            SEL_STATUS: bus_rdata = status_w;
            default:    bus_rdata = '0;
         endcase
      end
   end

   assign tick_irq = pend_q[PF_TIMER];
endmodule

// File: rtl/ostmr_chk.sv
module ostmr_chk
   import ostmr_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              tick_irq,
   input logic [DATA_W-1:0] stamp_q,
   input logic [DATA_W-1:0] count_q,
   input logic [DATA_W-1:0] ctl_q,
   input logic [1:0]        pend_q
);
   localparam logic [DATA_W-1:0] LOW_MASK = DATA_W'((1 << CTRL_BITS) - 1);

   logic w_stamp, w_reload, w_status, mapped;
   assign w_stamp  = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFF_STAMP));
   assign w_reload = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFF_RELOAD));
   assign w_status = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFF_STATUS));
   assign mapped   = (bus_addr == ADDR_W'(OFF_STAMP))  || (bus_addr == ADDR_W'(OFF_COUNT)) ||
                     (bus_addr == ADDR_W'(OFF_RELOAD)) || (bus_addr == ADDR_W'(OFF_STATUS));

   AST_STAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !w_stamp |=> stamp_q == $past(stamp_q) + 1'b1); // R2
   AST_STAMP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (stamp_q == {DATA_W{1'b1}}) && !w_stamp |=> pend_q[1]); // R3
   AST_LOAD_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      w_reload && bus_wdata[BIT_EN] |=> count_q == ($past(bus_wdata) & ~LOW_MASK)); // R4
   AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q[BIT_EN] && (count_q != '0) && !w_reload |=> count_q == $past(count_q) - 1'b1); // R5
   AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q[BIT_EN] && !ctl_q[BIT_ONCE] && (count_q == '0) && !w_reload
      |=> (count_q == ($past(ctl_q) & ~LOW_MASK)) && pend_q[0]); // R6
   AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q[BIT_EN] && ctl_q[BIT_ONCE] && (count_q == '0) && !w_reload
      |=> !ctl_q[BIT_EN] && (count_q == '0) && pend_q[0]); // R7
   AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q[0] && !(w_status && bus_wdata[ST_TIMER]) |=> pend_q[0]); // R8
   AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tick_irq) |-> $past(ctl_q[BIT_EN] && (count_q == '0))); // R9
   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bus_sel && !bus_wr && !mapped |-> bus_rdata == '0); // R10
   AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_q[BIT_EN] && !w_reload |=> $stable(count_q)); // R11
endmodule

bind os_tick_timer ostmr_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .tick_irq  (tick_irq),
   .stamp_q   (stamp_q),
   .count_q   (count_q),
   .ctl_q     (ctl_q),
   .pend_q    (pend_q)
);

// File: tb/os_tick_timer_test.sv
`timescale 1ns/1ps
module os_tick_timer_test;
   localparam int DW = 32;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          tick_irq;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;   // 50 MHz

   os_tick_timer #(.DATA_W(DW), .ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tick_irq(tick_irq)
   );

   task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%h expected=%h", req, got, exp);
      end
   endtask

   task automatic peek(input logic [AW-1:0] a, output logic [DW-1:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #2;
      d = bus_rdata;
   endtask

   task automatic poke(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      #1;
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [DW-1:0] d;
      // R1: reset state
      repeat (3) @(posedge clk);
      #2;
      peek(8'h00, d); check("R1 stamp", d, 0);
      peek(8'h04, d); check("R1 count", d, 0);
      peek(8'h08, d); check("R1 reload", d, 0);
      peek(8'h20, d); check("R1 status", d, 0);
      check("R1 irq", {31'd0, tick_irq}, 0);
      @(negedge clk); rst_n = 1'b1;

      // R2: timestamp load and step
      poke(8'h00, 32'h0000_1000);
      peek(8'h00, d); check("R2 load", d, 32'h1000);
      for (int n = 1; n <= 5; n++) begin
         step(); peek(8'h00, d); check("R2 step", d, 32'h1000 + n);
      end
      poke(8'h00, 32'h0);
      peek(8'h00, d); check("R2 zero", d, 0);

      // R3: wrap sets status bit 2
      poke(8'h00, 32'hFFFF_FFF0);
      for (int k = 1; k <= 15; k++) step();
      peek(8'h20, d); check("R3 before wrap", d & 32'h4, 0);
      step();
      peek(8'h20, d); check("R3 wrap flag", d, 32'h4);
      peek(8'h00, d); check("R3 wrapped", d, 0);
      check("R9 stamp flag no irq", {31'd0, tick_irq}, 0);
      poke(8'h20, 32'h4);
      peek(8'h20, d); check("R8 clear stamp", d, 0);

      // R4 R5 R6: periodic sweep over reload values
      for (int r = 0; r <= 28; r += 4) begin
         logic [DW-1:0] w;
         w = r | 1 | ((r & 8) ? 0 : 0);
         poke(8'h08, w);
         peek(8'h08, d); check("R4 readback", d, w);
         for (int k = 0; k <= 2*r + 3; k++) begin
            if (k > 0) step();
            peek(8'h04, d); check("R6 periodic count", d, r - (k % (r + 1)));
         end
         peek(8'h20, d); check("R6 pending", d, 1);
         check("R9 irq high", {31'd0, tick_irq}, 1);
         poke(8'h08, 0);
         poke(8'h20, 1);
         peek(8'h20, d); check("R8 clear timer", d, 0);
         check("R9 irq low", {31'd0, tick_irq}, 0);
      end

      // R4: low bits of a reload value never reach the count
      poke(8'h08, 32'h0000_0103);
      peek(8'h04, d); check("R4 masked load", d, 32'h100);
      poke(8'h08, 0);

      // R7: one-shot sweep
      for (int i = 0; i < 3; i++) begin
         int r;
         r = (i == 0) ? 0 : (i == 1) ? 8 : 20;
         poke(8'h08, r | 3);
         for (int k = 0; k <= r + 3; k++) begin
            if (k > 0) step();
            peek(8'h04, d); check("R7 oneshot count", d, (k <= r) ? r - k : 0);
            peek(8'h20, d); check("R7 oneshot pending", d, (k >= r + 1) ? 1 : 0);
         end
         peek(8'h08, d); check("R7 enable cleared", d, r | 2);
         poke(8'h20, 1);
         for (int k = 0; k < 4; k++) step();
         peek(8'h20, d); check("R7 no second expiry", d, 0);
         peek(8'h04, d); check("R7 count stays zero", d, 0);
      end

      // R8: expiry on the same edge as a clear keeps the flag
      poke(8'h08, 1);
      step(); step();
      poke(8'h20, 1);
      peek(8'h20, d); check("R8 set beats clear", d, 1);
      poke(8'h20, 32'h0000_0000);
      peek(8'h20, d); check("R8 write zero keeps", d, 1);
      poke(8'h08, 0);
      poke(8'h20, 1);
      peek(8'h20, d); check("R8 cleared", d, 0);

      // R11: disable holds the count
      poke(8'h08, 101);
      for (int k = 0; k < 5; k++) step();
      poke(8'h08, 0);
      peek(8'h04, d); check("R11 hold", d, 95);
      peek(8'h08, d); check("R11 reload zero", d, 0);
      for (int k = 0; k < 10; k++) step();
      peek(8'h04, d); check("R11 still held", d, 95);
      peek(8'h20, d); check("R11 no expiry", d, 0);

      // R10: unmapped reads, ignored writes
      poke(8'h04, 32'hDEAD_BEEC);
      peek(8'h04, d); check("R10 count write ignored", d, 95);
      poke(8'h0C, 32'hFFFF_FFFF);
      poke(8'h10, 32'hFFFF_FFFF);
      peek(8'h08, d); check("R10 unmapped write", d, 0);
      peek(8'h04, d); check("R10 unmapped write count", d, 95);
      peek(8'h0C, d); check("R10 read 0C", d, 0);
      peek(8'h10, d); check("R10 read 10", d, 0);
      peek(8'h24, d); check("R10 read 24", d, 0);
      peek(8'hFC, d); check("R10 read FC", d, 0);
      peek(8'h20, d); check("R8 reserved bits", d & 32'hFFFF_FFFA, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule